// File: doc/BRIEF.md
# Multi-Lane Serial Master Transfer Engine

This block is a serial peripheral master that moves words over one, two or four data lines. A host sets a lane mode, a direction bit and a clock-count field, then writes a word to start a transfer. In single-lane mode every transfer is full duplex: the word goes out on line 0 while line 1 is sampled. In dual or quad mode the host either transmits on the active lines, or sets the direction bit for receive. In receive, the written word is a dummy. It only starts the serial clock while the slave drives the lines.

One holding register queues the next word, so the serial clock keeps running with no gap between words. A completed receive word lands in a receive buffer. Three status flags each gate an interrupt: transmit-buffer-empty, receive-buffer-full and overrun. The slave select line follows a host bit directly. The serial clock idles low. Outputs change after the falling edge and inputs are captured at the rising edge.

Top module: `mlspi_master`

## Requirements
- R1: Mode field values: 0 is single lane, 1 is dual, 2 is quad, and 3 is treated as single. Words travel most significant bit first, and within one clock the highest active line carries the most significant bit.
- R2: In single mode a word write starts a full-duplex transfer. The word is driven on line 0 with enable pattern 4'b0001, and line 1 is sampled. The direction bit has no effect in single mode.
- R3: In dual or quad mode with the direction bit at 1, all four output enables stay 0 and the lines are sampled on each clock.
- R4: In dual or quad mode with the direction bit at 0, the word is driven with enables 4'b0011 (dual) or 4'b1111 (quad), and the receive-full flag is not set.
- R5: One transfer gives clock-length field plus one serial clock pulses, from 1 to 16. The word width is that count times the lane count. Received data is right-aligned with the upper bits zero, and only the low word-width bits of a transmit word are sent. The serial clock is low when idle.
- R6: After the last falling clock edge of a capturing transfer, the received word appears on the receive data port and the receive-full flag (flag bit 1) sets.
- R7: If a capturing transfer completes while the receive-full flag is set and not being read in that cycle, the receive buffer takes the new word and the overrun flag (flag bit 2) sets.
- R8: The transmit-empty flag (flag bit 0) is 1 after reset, clears on a word write and sets when the queued word moves into the shifter. A word written during a transfer follows with consecutive rising edges spaced evenly and no gap.
- R9: Writing 1 to a bit of the clear input clears the matching flag. The receive-full flag also clears on a receive data read.
- R10: The interrupt output is high exactly when some flag is set together with its enable bit (same bit positions as the flags).
- R11: The active-low slave select output is the inverse of the host select bit and is never changed by the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Lane mode: 0 single, 1 dual, 2 quad, 3 single |
| rx_dir_i | input | 1 | 1 selects receive in dual/quad mode |
| clk_len_i | input | 4 | Serial clocks per transfer minus one |
| ss_assert_i | input | 1 | Host slave select bit, active high |
| tx_wr_i | input | 1 | Word write strobe |
| tx_data_i | input | 64 | Transmit or dummy word, right-aligned |
| rx_rd_i | input | 1 | Receive data read strobe |
| rx_data_o | output | 64 | Receive buffer, right-aligned |
| flag_clr_i | input | 3 | Write-one-to-clear for {overrun, rx full, tx empty} |
| irq_en_i | input | 3 | Interrupt enables, same bit order as flags |
| flags_o | output | 3 | {overrun, rx full, tx empty} |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock |
| ss_n_o | output | 1 | Slave select, active low |
| sd_o | output | 4 | Data line output values |
| sd_oe_o | output | 4 | Data line output enables |
| sd_i | input | 4 | Data line input values |

## Verification
The bench builds the block with a half-period of two system cycles. Each serial clock then takes four cycles, so a full 64-bit quad transfer and a back-to-back pair of 8-clock words stay short. The gap-free handover is checked by timing the rising serial edges against that fixed 16 ns spacing. Line 0 is looped to line 1 in single mode, so full-duplex results can be predicted from the written word. A bench slave shifts out known words on the falling edges for dual and quad receive.

// File: rtl/mlspi_master.sv
module mlspi_master #(
  parameter int HALF_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic        rx_dir_i,
  input  logic [3:0]  clk_len_i,
  input  logic        ss_assert_i,
  input  logic        tx_wr_i,
  input  logic [63:0] tx_data_i,
  input  logic        rx_rd_i,
  output logic [63:0] rx_data_o,
  input  logic [2:0]  flag_clr_i,
  input  logic [2:0]  irq_en_i,
  output logic [2:0]  flags_o,
  output logic        irq_o,
  output logic        sclk_o,
  output logic        ss_n_o,
  output logic [3:0]  sd_o,
  output logic [3:0]  sd_oe_o,
  input  logic [3:0]  sd_i
);
  localparam int WMAX = 64;
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

  logic [63:0]   txb, sh, rxb, next_sh;
  logic          txb_full, busy, sclk_q;
  logic [PW-1:0] ph;
  logic [3:0]    left;
  logic [1:0]    lanes, new_lanes;
  logic          cur_drive, cur_cap;
  logic [3:0]    samp;
  logic          tbe, rbf, ovr;
  logic [6:0]    new_w;

  assign new_lanes = (mode_i == 2'd1) ? 2'd1 : (mode_i == 2'd2) ? 2'd2 : 2'd0;
  assign new_w     = 7'({3'b0, clk_len_i} + 7'd1) << new_lanes;

  logic edge_tick, rise, fall, last_fall, load_go, done_cap;
  assign edge_tick = busy && (ph == PH_LAST);
  assign rise      = edge_tick && !sclk_q;
  assign fall      = edge_tick && sclk_q;
  assign last_fall = fall && (left == 4'd0);
  assign load_go   = txb_full && (!busy || last_fall);
  assign done_cap  = last_fall && cur_cap;

  always_comb begin
    case (lanes)
      2'd1:    next_sh = {sh[61:0], samp[1:0]};
      2'd2:    next_sh = {sh[59:0], samp[3:0]};
      default: next_sh = {sh[62:0], samp[1]};
    endcase
  end

  always_comb begin
    sd_o    = 4'b0;
    sd_oe_o = 4'b0;
    case (lanes)
      2'd1:    begin sd_o[1:0] = sh[63:62]; sd_oe_o = 4'b0011; end
      2'd2:    begin sd_o      = sh[63:60]; sd_oe_o = 4'b1111; end
      default: begin sd_o[0]   = sh[63];    sd_oe_o = 4'b0001; end
    endcase
    if (!(busy && cur_drive)) sd_oe_o = 4'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb <= '0; txb_full <= 1'b0;
    end else begin
      if (tx_wr_i) txb <= tx_data_i;
      txb_full <= tx_wr_i ? 1'b1 : (load_go ? 1'b0 : txb_full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; busy <= 1'b0; sclk_q <= 1'b0; ph <= '0; left <= '0;
      lanes <= 2'd0; cur_drive <= 1'b0; cur_cap <= 1'b0; samp <= '0;
    end else begin
      if (busy) ph <= edge_tick ? '0 : ph + 1'b1;
      if (rise) begin
        sclk_q <= 1'b1;
        samp   <= sd_i;
      end
      if (fall) begin
        sclk_q <= 1'b0;
        sh     <= next_sh;
        left   <= left - 4'd1;
        if (last_fall) busy <= 1'b0;
      end
      if (load_go) begin
        sh        <= txb << (7'(WMAX) - new_w);
        busy      <= 1'b1;
        sclk_q    <= 1'b0;
        ph        <= '0;
        left      <= clk_len_i;
        lanes     <= new_lanes;
        cur_drive <= (new_lanes == 2'd0) || !rx_dir_i;
        cur_cap   <= (new_lanes == 2'd0) || rx_dir_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb <= '0; tbe <= 1'b1; rbf <= 1'b0; ovr <= 1'b0;
    end else begin
      if (done_cap) rxb <= next_sh;
      if (tx_wr_i)            tbe <= 1'b0;
      else if (load_go)       tbe <= 1'b1;
      else if (flag_clr_i[0]) tbe <= 1'b0;
      if (done_cap)                          rbf <= 1'b1;
      else if (rx_rd_i || flag_clr_i[1])     rbf <= 1'b0;
      if (done_cap && rbf && !rx_rd_i)       ovr <= 1'b1;
      else if (flag_clr_i[2])                ovr <= 1'b0;
    end
  end

  assign flags_o   = {ovr, rbf, tbe};
  assign irq_o     = |(flags_o & irq_en_i);
  assign rx_data_o = rxb;
  assign sclk_o    = sclk_q;
  assign ss_n_o    = ~ss_assert_i;
endmodule

module mlspi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done_cap,
  input logic       sclk_o,
  input logic       rx_rd_i,
  input logic [2:0] flags_o,
  input logic [2:0] irq_en_i,
  input logic       irq_o,
  input logic       ss_assert_i,
  input logic       ss_n_o,
  input logic [3:0] sd_oe_o
);
  assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_o);
  assert_oe_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe_o == 4'b0000) || (sd_oe_o == 4'b0001) || (sd_oe_o == 4'b0011) || (sd_oe_o == 4'b1111));
  assert_oe_off_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sd_oe_o == 4'b0000));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_i && !done_cap) |=> !flags_o[1]);
  assert_ovr_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[2]) |-> $past(flags_o[1]));
  assert_rbf_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_cap |=> flags_o[1]);
  assert_irq_rbf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[1] && irq_en_i[1]) |-> irq_o);
  assert_ss_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ss_assert_i) |-> $stable(ss_n_o));
endmodule

bind mlspi_master mlspi_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_cap(done_cap), .sclk_o(sclk_o),
  .rx_rd_i(rx_rd_i), .flags_o(flags_o), .irq_en_i(irq_en_i), .irq_o(irq_o),
  .ss_assert_i(ss_assert_i), .ss_n_o(ss_n_o), .sd_oe_o(sd_oe_o)
);

// File: tb/mlspi_master_tb_top.sv
module mlspi_master_tb_top;
  localparam int H = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] mode_i = '0; logic rx_dir_i = 1'b0; logic [3:0] clk_len_i = '0;
  logic ss_assert_i = 1'b0, tx_wr_i = 1'b0; logic [63:0] tx_data_i = '0;
  logic rx_rd_i, mon_rd = 1'b0, man_rd = 1'b0;
  logic [63:0] rx_data_o; logic [2:0] flag_clr_i = '0, irq_en_i = '0, flags_o;
  logic irq_o, sclk_o, ss_n_o; logic [3:0] sd_o, sd_oe_o, sd_i;

  assign rx_rd_i = mon_rd | man_rd;

  mlspi_master #(.HALF_CYC(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rx_dir_i(rx_dir_i), .clk_len_i(clk_len_i),
    .ss_assert_i(ss_assert_i), .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .rx_rd_i(rx_rd_i),
    .rx_data_o(rx_data_o), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i), .flags_o(flags_o),
    .irq_o(irq_o), .sclk_o(sclk_o), .ss_n_o(ss_n_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sd_i(sd_i));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, got, exp); end
  endtask

  // bench slave and line monitor
  int b_lanes = 1, nshift = 0, base = 0, nrise = 0;
  logic loop_en = 1'b1; logic [63:0] slv_seed = '0, cap = '0, slv_now;
  time rise_at [0:1023];
  assign slv_now = slv_seed << ((nshift - base) * b_lanes);
  assign sd_i = (b_lanes == 4) ? slv_now[63:60] :
                (b_lanes == 2) ? {2'b00, slv_now[63:62]} :
                {2'b00, (loop_en ? sd_o[0] : slv_now[63]), 1'b0};
  always @(negedge sclk_o) nshift++;
  always @(posedge sclk_o) begin
    nrise++;
    rise_at[nrise] = $time;
    if (b_lanes == 4) cap = {cap[59:0], sd_o};
    else if (b_lanes == 2) cap = {cap[61:0], sd_o[1:0]};
    else cap = {cap[62:0], sd_o[0]};
  end

  // scoreboard
  logic [63:0] exp_q[$];
  logic mon_en = 1'b1;
  always @(negedge clk) begin
    if (mon_rd) mon_rd = 1'b0;
    else if (rst_n && mon_en && flags_o[1]) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected word", rx_data_o, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(rx_data_o == e, "R6 rx word", rx_data_o, e);
      end
      mon_rd = 1'b1;
    end
  end

  task automatic xfer(input logic [1:0] md, input logic dr, input logic [3:0] cl,
                      input logic [63:0] tx, input logic [63:0] sw, input logic lp,
                      input logic push, input logic [63:0] expv,
                      output logic [3:0] oe_mid, output int rises, output logic [63:0] txcap);
    int ln, n, w, n0;
    logic [63:0] mask;
    ln = (md == 2'd1) ? 2 : (md == 2'd2) ? 4 : 1;
    n = int'(cl) + 1; w = n * ln;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    @(negedge clk);
    mode_i = md; rx_dir_i = dr; clk_len_i = cl; b_lanes = ln; loop_en = lp;
    slv_seed = sw << (64 - w); base = nshift; n0 = nrise;
    if (push) exp_q.push_back(expv);
    tx_wr_i = 1'b1; tx_data_i = tx;
    @(negedge clk); tx_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    oe_mid = sd_oe_o;
    repeat (2 * H * n + 2) @(negedge clk);
    rises = nrise - n0;
    txcap = cap & mask;
  endtask

  initial begin
    repeat (1_000_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] oe; int r; logic [63:0] tc; int n0;
    repeat (3) @(negedge clk);
    chk(flags_o == 3'b001, "R8 reset flags", 64'(flags_o), 64'h1);
    chk(!sclk_o && sd_oe_o == 0 && !irq_o, "R5 reset idle", {sclk_o, sd_oe_o, irq_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 slave select follows host bit
    ss_assert_i = 1'b1; #1;
    chk(ss_n_o == 1'b0, "R11 ss asserted", 64'(ss_n_o), 0);

    // R2 single full duplex loopback, 8 clocks
    xfer(2'd0, 1'b0, 4'd7, 64'hFFFF_0000_0000_5A96, 0, 1, 1, 64'h96, oe, r, tc);
    chk(oe == 4'b0001, "R2 single enables", 64'(oe), 64'h1);
    chk(r == 8, "R5 clock count 8", 64'(r), 8);
    chk(ss_n_o == 1'b0, "R11 ss unchanged by transfer", 64'(ss_n_o), 0);

    // R2 direction ignored in single mode
    xfer(2'd0, 1'b1, 4'd3, 64'hC, 0, 1, 1, 64'hC, oe, r, tc);
    chk(oe == 4'b0001, "R2 dir ignored single", 64'(oe), 64'h1);

    // R1 mode 3 as single
    xfer(2'd3, 1'b1, 4'd3, 64'h9, 0, 1, 1, 64'h9, oe, r, tc);
    chk(oe == 4'b0001 && r == 4, "R1 mode3 single", {oe, 32'(r)}, {4'b0001, 32'd4});

    // R5 one clock
    xfer(2'd0, 1'b0, 4'd0, 64'h3, 0, 1, 1, 64'h1, oe, r, tc);
    chk(r == 1, "R5 single clock", 64'(r), 1);

    // R3 quad receive, 4 clocks = 16 bits
    xfer(2'd2, 1'b1, 4'd3, 64'hFFFF, 64'hA5C3, 0, 1, 64'hA5C3, oe, r, tc);
    chk(oe == 4'b0000, "R3 quad rx no drive", 64'(oe), 0);
    chk(r == 4, "R5 quad clocks", 64'(r), 4);

    // R3 dual receive, 16 clocks = 32 bits
    xfer(2'd1, 1'b1, 4'd15, 64'h0, 64'h1234_9ABC, 0, 1, 64'h1234_9ABC, oe, r, tc);
    chk(oe == 4'b0000 && r == 16, "R3 dual rx", {oe, 32'(r)}, {4'b0, 32'd16});

    // R4 dual transmit, 6 clocks = 12 bits
    xfer(2'd1, 1'b0, 4'd5, 64'hF_FFFF_FB2D, 0, 0, 0, 0, oe, r, tc);
    chk(oe == 4'b0011, "R4 dual tx enables", 64'(oe), 64'h3);
    chk(tc == 64'hB2D, "R1 dual tx order", tc, 64'hB2D);
    chk(flags_o[1] == 1'b0, "R4 no rx full on tx", 64'(flags_o), 0);

    // R4 quad transmit, full 64 bits
    xfer(2'd2, 1'b0, 4'd15, 64'hDEAD_BEEF_0123_4567, 0, 0, 0, 0, oe, r, tc);
    chk(oe == 4'b1111, "R4 quad tx enables", 64'(oe), 64'hF);
    chk(tc == 64'hDEAD_BEEF_0123_4567, "R4 quad tx word", tc, 64'hDEAD_BEEF_0123_4567);

    // R7 overrun: two words without reading
    mon_en = 1'b0;
    xfer(2'd2, 1'b1, 4'd1, 0, 64'h3C, 0, 0, 0, oe, r, tc);
    chk(flags_o[1] && !flags_o[2], "R6 full no overrun", 64'(flags_o), 64'h3);
    xfer(2'd2, 1'b1, 4'd1, 0, 64'hE1, 0, 0, 0, oe, r, tc);
    chk(flags_o[2] == 1'b1, "R7 overrun set", 64'(flags_o), 64'h7);
    chk(rx_data_o == 64'hE1, "R7 overwritten", rx_data_o, 64'hE1);

    // R10 interrupt gating
    @(negedge clk); irq_en_i = 3'b100; #1;
    chk(irq_o == 1'b1, "R10 irq overrun", 64'(irq_o), 1);
    // R9 write-one clear
    @(negedge clk); flag_clr_i = 3'b100;
    @(negedge clk); flag_clr_i = 3'b000;
    chk(flags_o[2:1] == 2'b01, "R9 clear overrun only", 64'(flags_o), 64'h3);
    chk(irq_o == 1'b0, "R10 irq low after clear", 64'(irq_o), 0);
    man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
    chk(flags_o[1] == 1'b0, "R9 read clears full", 64'(flags_o), 64'h1);
    irq_en_i = 3'b001; #1;
    chk(irq_o == 1'b1, "R10 irq tx empty", 64'(irq_o), 1);
    @(negedge clk); flag_clr_i = 3'b001;
    @(negedge clk); flag_clr_i = 3'b000;
    chk(flags_o[0] == 1'b0 && !irq_o, "R9 clear tx empty", {flags_o, irq_o}, 0);
    irq_en_i = 3'b000;
    mon_en = 1'b1;

    // R8 continuous: second word queued mid transfer
    mode_i = 2'd0; rx_dir_i = 1'b0; clk_len_i = 4'd7; b_lanes = 1; loop_en = 1'b1;
    n0 = nrise;
    exp_q.push_back(64'h6E); exp_q.push_back(64'hB1);
    tx_wr_i = 1'b1; tx_data_i = 64'h6E;
    @(negedge clk); tx_wr_i = 1'b0;
    chk(flags_o[0] == 1'b0, "R8 empty cleared by write", 64'(flags_o), 0);
    @(negedge clk);
    chk(flags_o[0] == 1'b1, "R8 empty after load", 64'(flags_o), 1);
    repeat (3) @(negedge clk);
    tx_wr_i = 1'b1; tx_data_i = 64'hB1;
    @(negedge clk); tx_wr_i = 1'b0;
    repeat (2 * H * 16 + 6) @(negedge clk);
    chk(nrise - n0 == 16, "R8 total clocks", 64'(nrise - n0), 16);
    chk(rise_at[n0 + 16] - rise_at[n0 + 1] == time'(15 * 2 * H * 4), "R8 no gap",
        64'(rise_at[n0 + 16] - rise_at[n0 + 1]), 64'(15 * 2 * H * 4));
    chk(exp_q.size() == 0, "R6 all words seen", 64'(exp_q.size()), 0);

    ss_assert_i = 1'b0; #1;
    chk(ss_n_o == 1'b1, "R11 ss released", 64'(ss_n_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule